// File: doc/BRIEF.md
# Signed/Unsigned Decimal Result Formatter

This block turns a binary result word into a sign flag and three decimal digits for a numeric readout. A mode input selects how the word is read. In signed mode the word is read as two's complement. A negative word is negated to its magnitude and the sign flag is raised. In unsigned mode the word is taken as it is and the sign flag stays low.

The conversion is sequential. A one-cycle start pulse captures the word and the mode. The block then runs one shift-and-add-3 step per clock for each bit of the word. Only three decimal places are kept, so the digits equal the magnitude modulo 1000. When the last step is done, a one-cycle done pulse marks the digits as valid, and they stay unchanged until the next accepted start.

Per-digit blank flags support leading-zero suppression on the display. Segment encoding, digit multiplexing and the producer of the word are outside this block.

Top module: `dec_result_fmt`

## Requirements
- R1: With signedMode = 0, the outputs after done give (valueIn mod 1000) as hundredsDigit, tensDigit and onesDigit, each a 4-bit BCD code, and signNeg = 0. For example, 0xFFFFFFFF gives 2, 9, 5.
- R2: With signedMode = 1 and valueIn bit 31 set, signNeg = 1 and the digits give the two's-complement magnitude modulo 1000. For example, 0xFFFFFFFF gives -001 and 0xFFFFFFFC gives -004.
- R3: With signedMode = 1 and valueIn bit 31 clear, signNeg = 0 and the digits give valueIn modulo 1000.
- R4: With signedMode = 1 and valueIn = 0x80000000, the magnitude is taken as 2147483648, so the output is signNeg = 1 with digits 6, 4, 8.
- R5: done is high for exactly one cycle. If start is sampled at clock edge n, done is high between edges n+32 and n+33.
- R6: After done, the digits and signNeg hold their values until the next accepted start.
- R7: A start that arrives while a conversion is running is ignored. It produces no extra done and does not change the result of the running conversion.
- R8: blankHundreds = 1 exactly when hundredsDigit is 0. blankTens = 1 exactly when both hundredsDigit and tensDigit are 0. The ones digit has no blank flag and is never blanked.
- R9: While rst is high at a clock edge, the digits, signNeg and done are cleared to 0 after that edge. rst is synchronous and active high.
- R10: Each digit register always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures valueIn and signedMode |
| signedMode | input | 1 | 1: read the word as two's complement; 0: read it as unsigned |
| valueIn | input | 32 | Result word to convert |
| signNeg | output | 1 | Minus indication |
| hundredsDigit | output | 4 | BCD hundreds digit |
| tensDigit | output | 4 | BCD tens digit |
| onesDigit | output | 4 | BCD ones digit |
| blankHundreds | output | 1 | Suppress the hundreds digit |
| blankTens | output | 1 | Suppress the tens digit |
| done | output | 1 | One-cycle pulse: the digits are valid |

## Verification
The assertions check properties that must hold on every cycle:
- every digit register stays in the BCD range;
- done never lasts longer than one cycle;
- the sign does not move while shifting;
- the digits stay frozen whenever the control issues neither a load nor a shift.

The assertions cannot show whether the digits are numerically right, whether the done pulse comes with the exact latency, whether a start during a conversion is ignored, or how the most negative word and the all-ones word come out in each mode. Only the bench's scenarios show these, by comparing the outputs against an independent modulo-1000 model.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int DIGITS = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fmt_state_e;

  typedef struct packed {
    logic load;
    logic shift;
  } fmt_ctrl_t;
endpackage

// File: rtl/fmt_control.sv
module fmt_control
  import fmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output fmt_ctrl_t ctl,
  output logic      done
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  fmt_state_e state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctl.load  = (state == ST_IDLE) && start;
    ctl.shift = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // One-cycle completion strobe
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fmt_ctrl_t               ctl,
  input  logic                    signedMode,
  input  logic [DATA_W-1:0]       valueIn,
  output logic                    signNeg,
  output logic [DIGITS-1:0][3:0]  bcd
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] magnitude;
  logic              isNeg;
  logic [DIGITS-1:0][3:0] adj;
  logic [DIGITS-1:0][3:0] bcdNext;

  always_comb begin
    isNeg     = signedMode && valueIn[DATA_W-1];
    magnitude = isNeg ? (~valueIn + 1'b1) : valueIn;
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic carryIn;
    always_comb begin
      adj[i] = (bcd[i] >= 4'd5) ? bcd[i] + 4'd3 : bcd[i];
    end
    if (i == 0) begin : g_low
      always_comb carryIn = shReg[DATA_W-1];
    end else begin : g_high
      always_comb carryIn = adj[i-1][3];
    end
    always_comb bcdNext[i] = {adj[i][2:0], carryIn};

    assert_bcd_range_R10: assert property (@(posedge clk) disable iff (rst)
      bcd[i] <= 4'd9);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg   <= '0;
      bcd     <= '0;
      signNeg <= 1'b0;
    end else if (ctl.load) begin
      shReg   <= magnitude;
      bcd     <= '0;
      signNeg <= isNeg;
    end else if (ctl.shift) begin
      shReg <= shReg << 1;
      bcd   <= bcdNext;
    end
  end

  // Sign captured at load must not drift during the run (R7)
  assert_sign_stable_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.shift |=> $stable(signNeg));

  // Result frozen while idle (R6)
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctl.load && !ctl.shift) |=> $stable(bcd));
endmodule

// File: rtl/dec_result_fmt.sv
module dec_result_fmt
  import fmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              signedMode,
  input  logic [DATA_W-1:0] valueIn,
  output logic              signNeg,
  output logic [3:0]        hundredsDigit,
  output logic [3:0]        tensDigit,
  output logic [3:0]        onesDigit,
  output logic              blankHundreds,
  output logic              blankTens,
  output logic              done
);
  fmt_ctrl_t ctl;
  logic [DIGITS-1:0][3:0] bcd;

  fmt_control #(.DATA_W(DATA_W)) u_control (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  fmt_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .signedMode (signedMode),
    .valueIn    (valueIn),
    .signNeg    (signNeg),
    .bcd        (bcd)
  );

  always_comb begin
    onesDigit     = bcd[0];
    tensDigit     = bcd[1];
    hundredsDigit = bcd[2];
    blankHundreds = (bcd[2] == 4'd0);
    blankTens     = (bcd[2] == 4'd0) && (bcd[1] == 4'd0);
  end
endmodule

// File: tb/dec_result_fmt_bench.sv
module dec_result_fmt_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [31:0] valueIn = '0;
  logic signNeg, blankHundreds, blankTens, done;
  logic [3:0] hundredsDigit, tensDigit, onesDigit;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;
  bit finished = 0;

  typedef struct {
    logic neg;
    logic [3:0] h, t, o;
    int due;
    string tag;
  } exp_t;

  exp_t sb[$];

  dec_result_fmt u_dec_result_fmt (
    .clk(clk), .rst(rst), .start(start), .signedMode(signedMode),
    .valueIn(valueIn), .signNeg(signNeg), .hundredsDigit(hundredsDigit),
    .tensDigit(tensDigit), .onesDigit(onesDigit),
    .blankHundreds(blankHundreds), .blankTens(blankTens), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  function automatic exp_t model(input logic [31:0] v, input bit m, input string tag);
    exp_t e;
    logic [31:0] mag;
    int r;
    e.neg = m && v[31];
    mag = e.neg ? (32'd0 - v) : v;
    r = int'(mag % 32'd1000);
    e.h = 4'(r / 100);
    e.t = 4'((r / 10) % 10);
    e.o = 4'(r % 10);
    e.tag = tag;
    e.due = 0;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each done
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prevDone)
        check(0, "R5", "done wider than one cycle", 2, 1);
      if (done) begin
        if (sb.size() == 0) begin
          check(0, "R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(signNeg == e.neg, e.tag, "sign", int'(signNeg), int'(e.neg));
          check(hundredsDigit == e.h, e.tag, "hundreds", int'(hundredsDigit), int'(e.h));
          check(tensDigit == e.t, e.tag, "tens", int'(tensDigit), int'(e.t));
          check(onesDigit == e.o, e.tag, "ones", int'(onesDigit), int'(e.o));
          check(cycleCount == e.due, "R5", "done latency", cycleCount, e.due);
          check(blankHundreds == (e.h == 0), "R8", "blankHundreds",
                int'(blankHundreds), int'(e.h == 0));
          check(blankTens == (e.h == 0 && e.t == 0), "R8", "blankTens",
                int'(blankTens), int'(e.h == 0 && e.t == 0));
        end
      end
    end
    prevDone <= done;
  end

  // Driver: called right after a negedge
  task automatic pulseStart(input logic [31:0] v, input bit m);
    start = 1'b1; valueIn = v; signedMode = m;
    @(negedge clk);
    start = 1'b0; valueIn = ~v; signedMode = ~m;
  endtask

  task automatic convert(input logic [31:0] v, input bit m, input string tag);
    exp_t e;
    e = model(v, m, tag);
    e.due = cycleCount + 33;
    sb.push_back(e);
    pulseStart(v, m);
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(done == 0 && signNeg == 0, "R9", "reset done/sign", int'(done) + int'(signNeg), 0);
    check({hundredsDigit, tensDigit, onesDigit} == 12'h000, "R9", "reset digits",
          int'({hundredsDigit, tensDigit, onesDigit}), 0);
    rst = 1'b0;
    @(negedge clk);

    convert(32'hFFFF_FFFF, 1'b0, "R1");
    convert(32'hFFFF_FFFF, 1'b1, "R2");
    convert(32'hFFFF_FFFC, 1'b1, "R2");
    convert(32'h8000_0000, 1'b1, "R4");
    convert(32'h8000_0000, 1'b0, "R1");
    convert(32'd0, 1'b1, "R3");
    convert(32'd0, 1'b0, "R1");
    convert(32'd999, 1'b1, "R3");
    convert(32'd1000, 1'b0, "R1");
    convert(32'd7, 1'b0, "R8");
    convert(32'd40, 1'b1, "R8");
    convert(32'd305, 1'b0, "R8");
    convert(32'hFFFF_FC18, 1'b1, "R2"); // -1000

    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      v = $urandom();
      if (i % 4 == 0) v = v % 2000;
      if (i % 2 == 1) convert(v, 1'b1, v[31] ? "R2" : "R3");
      else convert(v, 1'b0, "R1");
    end

    // R6: hold after done
    convert(32'd123456, 1'b0, "R1");
    repeat (20) @(negedge clk);
    check({hundredsDigit, tensDigit, onesDigit} == 12'h456, "R6", "hold digits",
          int'({hundredsDigit, tensDigit, onesDigit}), 12'h456);
    check(signNeg == 0, "R6", "hold sign", int'(signNeg), 0);

    // R7: start during run is ignored
    begin
      exp_t e;
      e = model(32'hFFFF_FF85, 1'b1, "R7"); // -123
      e.due = cycleCount + 33;
      sb.push_back(e);
      pulseStart(32'hFFFF_FF85, 1'b1);
      repeat (5) @(negedge clk);
      pulseStart(32'd789, 1'b0);
      while (sb.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
      check(hundredsDigit == 1 && tensDigit == 2 && onesDigit == 3 && signNeg == 1,
            "R7", "result after ignored start",
            int'({signNeg, hundredsDigit, tensDigit, onesDigit}), 'h1123);
    end

    // R9: reset after a result
    convert(32'd987, 1'b0, "R1");
    rst = 1'b1;
    @(negedge clk);
    check({signNeg, hundredsDigit, tensDigit, onesDigit, done} == '0, "R9",
          "reset clears outputs", int'({hundredsDigit, tensDigit, onesDigit}), 0);
    rst = 1'b0;
    @(negedge clk);
    convert(32'hFFFF_FFF0, 1'b1, "R2"); // -16 after reset

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cycleCount > 60000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycleCount, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule